// File: doc/BRIEF.md
# Multi-bank prefetching memory read port

This block sits between a host processor's strobe bus and an on-chip word-wide RAM. The host drives chip select, read and write strobes (all active low), an 18-bit address and a 32-bit write data word, and receives a 32-bit read word with a ready flag. The RAM side is a single synchronous port with one clock of read latency. The strobes are taken in through synchronisers, so the host may change them without regard to the block clock.

The upper two address bits choose a bank. For each non-zero bank code the block keeps its own read pointer and a one-word prefetch buffer. A write to a pointer register, with a bank code and a start byte address in the data word, moves that bank's pointer and starts a fetch at once. From then on every read strobe for that bank is answered from the buffer, whatever the lower address bits hold. The pointer then steps one word and the next word is fetched in the background. Streams to different banks may be interleaved freely, and each bank resumes where it stopped. Writes into memory space always go to the address on the bus. Bank code 00, or a bank whose pointer was never set, gives a plain direct read.

Top module: `prefetch_read_port`

## Requirements
- R1: After reset the ready flag is low, the RAM port is idle and no bank has a pointer, so every memory-space read is a direct read.
- R2: A write to offset 0008h (lower 16 address bits) sets the pointer of the bank whose code is in data bits [17:16] to the byte address in data bits [15:0]. Data code 00 changes no bank.
- R3: Address bits [17:16] pick the bank: 01, 10 and 11 are three independent banks. A read of a bank with a set pointer returns the RAM word at that pointer, whatever address bits [15:0] hold (as long as they are at or above 0400h).
- R4: Each completed read of a pointer-driven bank steps that bank's pointer by 4 bytes, so successive reads return successive words.
- R5: Each bank's pointer keeps its position while other banks are read or written.
- R6: Writing the pointer register again for one bank restarts that bank at the new address and leaves the other banks' positions unchanged.
- R7: A write strobe with an offset at or above 0400h performs exactly one RAM write of the data word at word address = offset bits [15:2]. Consecutive writes do not auto-increment and do not move any bank pointer.
- R8: A read in memory space with bank code 00, or with a bank whose pointer was never set, returns the RAM word at offset bits [15:2].
- R9: A read with an offset below 0400h returns zero. A write below 0400h other than to the pointer register performs no RAM write and changes no pointer.
- R10: The ready flag rises only once the word for the current read is available. It falls after the strobe ends, and the pointer steps once per strobe however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low |
| rd_n_i | input | 1 | Host read strobe, active low |
| wr_n_i | input | 1 | Host write strobe, active low |
| addr_i | input | 18 | Host address; [17:16] bank code, [15:0] byte offset |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data for the current strobe |
| rdy_o | output | 1 | Read data valid for the current strobe |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 14 | RAM word address |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, one clock after the request |

## Verification
The streaming function is tried with the two-bank interleave from the specification, with a long mixed sweep over all three banks, and with direct reads whose lower address bits change on every access. This separates a pointer that follows its own bank from one that follows the bus address or is shared between banks. Reads before any pointer load, with code 00 and below the memory space show that the fall-back and register paths do not touch any stream. Repeated writes to one address, a write placed ahead of a stream start, pointer reloads, a zero-code load and strobes held for many cycles check that the step is once per strobe and that writes neither increment nor disturb pointers.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    // how the read in progress is being served
    typedef enum logic [1:0] {
        RM_REG = 2'd0,   // register space, returns zero
        RM_PF  = 2'd1,   // served from a bank's prefetch buffer
        RM_DIR = 2'd2    // plain RAM read at the bus address
    } rd_mode_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/pfr_strobe_sync.sv
module pfr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic active_o,
    output logic start_o,
    output logic end_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, n;

    always_comb begin
        n      = q;
        n.sh   = {q.sh[STAGES-2:0], strobe_i};
        n.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign active_o = q.sh[STAGES-1];
    assign start_o  = q.sh[STAGES-1] & ~q.prev;
    assign end_o    = ~q.sh[STAGES-1] & q.prev;

endmodule

// File: rtl/pfr_bank_slot.sv
module pfr_bank_slot #(
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [OFF_W-1:0]  load_addr_i,
    input  logic              adv_i,
    input  logic              fill_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic [OFF_W-1:0]  ptr_o,
    output logic              loaded_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    import pfr_pkg::*;

    localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

    typedef struct packed {
        logic [OFF_W-1:0]  ptr;
        logic              loaded;
        logic              vld;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t q, n;

    always_comb begin
        n = q;
        // a returning word lands first; a pointer move in the same cycle voids it
        if (fill_i) begin
            n.data = fill_data_i;
            n.vld  = 1'b1;
        end
        if (load_i) begin
            n.ptr    = load_addr_i;
            n.loaded = 1'b1;
            n.vld    = 1'b0;
        end else if (adv_i) begin
            n.ptr = q.ptr + STEP;
            n.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign ptr_o    = q.ptr;
    assign loaded_o = q.loaded;
    assign valid_o  = q.vld;
    assign data_o   = q.data;

    AST_PTR_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.loaded) && !$past(load_i) && (q.ptr != $past(q.ptr)))
            |-> (q.ptr == $past(q.ptr) + STEP)); // R4

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !load_i && !adv_i) |=> q.vld); // R10

endmodule

// File: rtl/pfr_fetch_pick.sv
module pfr_fetch_pick #(
    parameter int NB    = 3,
    parameter int IDX_W = 2
) (
    input  logic [NB-1:0]    need_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    // lowest bank index wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (need_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prefetch_read_port.sv
module prefetch_read_port #(
    parameter int          OFF_W       = 16,
    parameter int          BANK_W      = 2,
    parameter int          DATA_W      = 32,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned MEM_BASE    = 32'h0400,
    parameter int unsigned PTR_REG_OFF = 32'h0008
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n_i,
    input  logic                    rd_n_i,
    input  logic                    wr_n_i,
    input  logic [OFF_W+BANK_W-1:0] addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    rdy_o,
    output logic                    ram_en_o,
    output logic                    ram_we_o,
    output logic [OFF_W-3:0]        ram_addr_o,
    output logic [DATA_W-1:0]       ram_wdata_o,
    input  logic [DATA_W-1:0]       ram_rdata_i
);

    import pfr_pkg::*;

    localparam int ADDR_W = OFF_W + BANK_W;
    localparam int NB     = (2 ** BANK_W) - 1;
    localparam int IDX_W  = BANK_W;
    localparam int RAM_AW = OFF_W - 2;
    localparam logic [OFF_W-1:0] MEM_BASE_W = OFF_W'(MEM_BASE);
    localparam logic [OFF_W-1:0] PTR_OFF_W  = OFF_W'(PTR_REG_OFF);

    typedef struct packed {
        logic              busy;
        rd_mode_e          mode;
        logic [IDX_W-1:0]  bank;
        logic              rdy;
        logic [DATA_W-1:0] rdata;
        logic              infl;
        logic              infl_dir;
        logic [IDX_W-1:0]  infl_bank;
    } ctl_t;

    ctl_t q, n;

    // ---------------- strobe synchronisers ----------------
    logic [1:0] strb_raw, strb_act, strb_st, strb_en;
    assign strb_raw[0] = ~cs_n_i & ~rd_n_i;
    assign strb_raw[1] = ~cs_n_i & ~wr_n_i;

    for (genvar s = 0; s < 2; s++) begin : g_sync
        pfr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (strb_raw[s]),
            .active_o (strb_act[s]),
            .start_o  (strb_st[s]),
            .end_o    (strb_en[s])
        );
    end

    logic rd_start, rd_end, wr_start;
    assign rd_start = strb_st[0];
    assign rd_end   = strb_en[0];
    assign wr_start = strb_st[1];

    logic [BANK_W-1:0] rd_code, wr_code;
    logic [OFF_W-1:0]  bus_off;
    assign rd_code = addr_i[ADDR_W-1:OFF_W];
    assign bus_off = addr_i[OFF_W-1:0];
    assign wr_code = wdata_i[ADDR_W-1:OFF_W];

    // ---------------- bank slots ----------------
    logic [OFF_W-1:0]  slot_ptr  [NB];
    logic [DATA_W-1:0] slot_data [NB];
    logic [NB-1:0]     slot_ld, slot_vld, need_v;
    logic [NB-1:0]     ld_v, adv_v, fill_v;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        pfr_bank_slot #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (ld_v[g]),
            .load_addr_i (wdata_i[OFF_W-1:0]),
            .adv_i       (adv_v[g]),
            .fill_i      (fill_v[g]),
            .fill_data_i (ram_rdata_i),
            .ptr_o       (slot_ptr[g]),
            .loaded_o    (slot_ld[g]),
            .valid_o     (slot_vld[g]),
            .data_o      (slot_data[g])
        );
        assign need_v[g] = slot_ld[g] & ~slot_vld[g]
                         & ~(q.infl & ~q.infl_dir & (q.infl_bank == IDX_W'(g)));
    end

    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;

    pfr_fetch_pick #(.NB(NB), .IDX_W(IDX_W)) u_pick (
        .need_i (need_v),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        n           = q;
        n.infl      = 1'b0;
        n.infl_dir  = 1'b0;
        ld_v        = '0;
        adv_v       = '0;
        fill_v      = '0;
        ram_en_o    = 1'b0;
        ram_we_o    = 1'b0;
        ram_addr_o  = bus_off[OFF_W-1:2];
        ram_wdata_o = wdata_i;

        // word returning from the RAM
        if (q.infl) begin
            if (q.infl_dir) begin
                if (q.busy) begin
                    n.rdata = ram_rdata_i;
                    n.rdy   = 1'b1;
                end
            end else begin
                fill_v[q.infl_bank] = 1'b1;
            end
        end

        // a stream read waiting for its buffer
        if (q.busy && (q.mode == RM_PF) && !q.rdy && slot_vld[q.bank]) begin
            n.rdata = slot_data[q.bank];
            n.rdy   = 1'b1;
        end

        if (rd_start) begin
            n.busy = 1'b1;
            n.rdy  = 1'b0;
            if (bus_off < MEM_BASE_W) begin
                n.mode  = RM_REG;
                n.rdata = '0;
                n.rdy   = 1'b1;
            end else if ((rd_code != '0) && slot_ld[rd_code - 1'b1]) begin
                n.mode = RM_PF;
                n.bank = rd_code - 1'b1;
            end else begin
                n.mode     = RM_DIR;
                ram_en_o   = 1'b1;
                ram_addr_o = bus_off[OFF_W-1:2];
                n.infl     = 1'b1;
                n.infl_dir = 1'b1;
            end
        end

        if (rd_end) begin
            n.busy = 1'b0;
            n.rdy  = 1'b0;
            if (q.busy && (q.mode == RM_PF)) begin
                adv_v[q.bank] = 1'b1;
            end
        end

        if (wr_start) begin
            if (bus_off == PTR_OFF_W) begin
                if (wr_code != '0) begin
                    ld_v[wr_code - 1'b1] = 1'b1;
                end
            end else if (bus_off >= MEM_BASE_W) begin
                ram_en_o   = 1'b1;
                ram_we_o   = 1'b1;
                ram_addr_o = bus_off[OFF_W-1:2];
            end
        end

        // background fetch only in a cycle where no pointer moves and the port is free
        if (!rd_start && !rd_end && !wr_start && pick_hit) begin
            ram_en_o    = 1'b1;
            ram_addr_o  = slot_ptr[pick_idx][OFF_W-1:2];
            n.infl      = 1'b1;
            n.infl_dir  = 1'b0;
            n.infl_bank = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rdata_o = q.rdata;
    assign rdy_o   = q.rdy;

    // ---------------- assertions ----------------
    AST_RDY_FALLS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        rd_end |=> !rdy_o); // R10

    AST_PF_RDY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_o) && (q.mode == RM_PF)) |-> $past(slot_vld[q.bank])); // R10

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.infl |-> $past(ram_en_o && !ram_we_o)); // R3

    AST_DIR_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.infl && q.infl_dir && q.busy && !rd_end) |=> rdy_o); // R8

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> !ram_we_o); // R7

    AST_PICK_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        pick_hit |-> (need_v[pick_idx] && slot_ld[pick_idx])); // R4

endmodule

// File: tb/tb_prefetch_read_port.sv
module tb_prefetch_read_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [17:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdy;
    logic        ram_en, ram_we;
    logic [13:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    bit done   = 0;

    logic [15:0] pb [4];
    bit          pl [4];
    logic [31:0] mem [int unsigned];

    always #5 clk = ~clk;

    prefetch_read_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n),
        .rd_n_i      (rd_n),
        .wr_n_i      (wr_n),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .rdy_o       (rdy),
        .ram_en_o    (ram_en),
        .ram_we_o    (ram_we),
        .ram_addr_o  (ram_addr),
        .ram_wdata_o (ram_wdata),
        .ram_rdata_i (ram_rdata)
    );

    function automatic logic [31:0] memval(input int unsigned wa);
        if (mem.exists(wa)) return mem[wa];
        return 32'h5A00_0000 ^ (wa * 32'h0001_0003);
    endfunction

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                mem[int'(ram_addr)] = ram_wdata;
                wr_cnt++;
            end else begin
                ram_rdata <= memval(int'(ram_addr));
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_read(input logic [17:0] a);
        logic [1:0]  c = a[17:16];
        logic [15:0] o = a[15:0];
        logic [31:0] v;
        if (o < 16'h0400) return 32'h0;
        if (c != 2'b00 && pl[c]) begin
            v = memval(int'(pb[c] >> 2));
            pb[c] = pb[c] + 16'd4;
            return v;
        end
        return memval(int'(o >> 2));
    endfunction

    task automatic cpu_write(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic load_ptr(input logic [1:0] c, input logic [15:0] start);
        cpu_write(18'h0_0008, {14'h0, c, start});
        if (c != 2'b00) begin
            pb[c] = start;
            pl[c] = 1'b1;
        end
    endtask

    task automatic cpu_read(input logic [17:0] a, input int hold, input string req);
        logic [31:0] exp;
        int n = 0;
        exp = expect_read(a);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk({req, " R10 ready low at strobe start"}, {31'h0, rdy}, 32'h0);
        while (!rdy && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!rdy) chk({req, " R10 ready timeout"}, 32'h0, 32'h1);
        else      chk(req, rdata, exp);
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base_cnt;
        for (int i = 0; i < 4; i++) begin pb[i] = '0; pl[i] = 1'b0; end
        repeat (4) @(negedge clk);
        chk("R1 ready in reset", {31'h0, rdy}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'h0, rdy}, 32'h0);
        chk("R1 RAM idle after reset", {31'h0, ram_en}, 32'h0);

        // R1 / R8: no pointer loaded, every bank reads directly
        for (int c = 0; c < 4; c++) begin
            cpu_read({c[1:0], 16'h4000 + 16'(c * 16'h0104)}, 0, "R1 R8 unloaded bank direct read");
        end

        // R9: register space reads return zero
        cpu_read(18'h0_0000, 0, "R9 register read 0000h");
        cpu_read(18'h1_0008, 1, "R9 register read pointer offset");
        cpu_read(18'h3_03FC, 0, "R9 register read 03FCh");

        // R7: writes go to the bus address, no increment
        base_cnt = wr_cnt;
        cpu_write(18'h0_5000, 32'hAAAA_0001);
        cpu_write(18'h0_5000, 32'hBBBB_0002);
        chk("R7 one RAM write per strobe", wr_cnt - base_cnt, 2);
        cpu_read(18'h0_5000, 0, "R7 R8 last write kept at same address");
        chk("R7 stored value", mem[32'h5000 >> 2], 32'hBBBB_0002);
        cpu_read(18'h0_5004, 0, "R7 no auto-increment of write address");

        // R9: write below memory space is ignored
        base_cnt = wr_cnt;
        cpu_write(18'h0_0100, 32'hDEAD_BEEF);
        chk("R9 low write makes no RAM write", wr_cnt - base_cnt, 0);

        // R2 / R5: two interleaved streams
        load_ptr(2'b01, 16'h4000);
        load_ptr(2'b10, 16'h4100);
        cpu_read(18'h1_0400, 0, "R3 bank1 first word 4000h");
        cpu_read(18'h1_FFFC, 2, "R3 bank1 ignores low bits 4004h");
        cpu_read(18'h1_8888, 0, "R4 bank1 word 4008h");
        for (int i = 0; i < 4; i++) begin
            cpu_read({2'b10, 16'h0400 + 16'(i * 16'h0230)}, i, "R4 bank2 stream 4100h..");
        end
        chk("R5 bank1 position model 400Ch", {16'h0, pb[1]}, 32'h0000_400C);
        cpu_read(18'h1_1234, 0, "R5 bank1 resumes at 400Ch");
        cpu_read(18'h2_0404, 0, "R5 bank2 resumes at 4110h");

        // R2: code 00 load is ignored; R9: low write leaves pointers alone
        cpu_write(18'h0_0008, {14'h0, 2'b00, 16'h9000});
        cpu_write(18'h0_0200, {14'h0, 2'b01, 16'h9000});
        cpu_read(18'h1_0800, 0, "R2 R9 bank1 unchanged after ignored writes");

        // R7 then R3: write ahead of a stream start on bank3
        base_cnt = wr_cnt;
        cpu_write(18'h3_7004, 32'hC0C0_7004);
        chk("R7 write with bank bits set", wr_cnt - base_cnt, 1);
        load_ptr(2'b11, 16'h7000);
        cpu_read(18'h3_0400, 0, "R3 bank3 first word");
        cpu_read(18'h3_0400, 0, "R3 R7 bank3 returns written word");
        chk("R7 bank3 word value", mem[32'h7004 >> 2], 32'hC0C0_7004);

        // R6: reload one bank only
        load_ptr(2'b10, 16'h6000);
        cpu_read(18'h2_4444, 0, "R6 bank2 restarted at 6000h");
        cpu_read(18'h1_4444, 0, "R6 bank1 unaffected by bank2 reload");
        cpu_read(18'h3_4444, 0, "R6 bank3 unaffected by bank2 reload");

        // R10: long strobes advance once
        cpu_read(18'h1_0400, 12, "R10 long strobe bank1");
        cpu_read(18'h1_0400, 0, "R10 next word after long strobe");

        // mixed sweep over all banks and direct reads
        for (int i = 0; i < 36; i++) begin
            logic [1:0]  c;
            logic [15:0] o;
            c = (i % 5 == 4) ? 2'b00 : 2'((i * 2) % 3 + 1);
            o = 16'h0400 | (16'(i * 16'h1357) & 16'hFFFC);
            cpu_read({c, o}, i % 4, "R3 R4 R5 R8 interleaved sweep");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule